// File: doc/BRIEF.md
# Fractional Time-of-Day Counter

This block keeps a time-of-day value as a seconds count, a nanosecond count and a 32-bit fraction of a nanosecond. On every core clock edge a 64-bit fixed-point increment is added to the nanosecond and fraction pair. Bits 63:32 of the increment are whole nanoseconds and bits 31:0 are the sub-nanosecond part. When the nanosecond field reaches one second it is reduced by exactly 10^9 and the remainder is kept, and the seconds counter steps by one. Because the remainder is kept, no time is lost at the seconds boundary.

Software uses a simple write strobe with a 2-bit register select. It can load the increment, replace the time in one step, or add a signed nanosecond offset in one step. It can also apply a frequency trim in scaled parts-per-million, which rescales the last loaded increment. A read strobe copies all three time fields into output registers on the same edge, so a read never returns a value split across a wrap. For correct single-wrap behaviour the whole-nanosecond part of the increment must stay below 10^9.

Top module: `tod_fracclk`

## Requirements
- R1: After reset the seconds, nanosecond and fraction fields are zero and the active increment is (10^9 << 32) / CLK_HZ, which is exactly 10 ns for CLK_HZ = 100 MHz.
- R2: On every clock edge with no set, the active increment is added to the {nanosecond, fraction} pair, and a carry out of the fraction adds one nanosecond.
- R3: When the nanosecond sum is at or above 1,000,000,000, 10^9 is subtracted, the remainder is kept and seconds increase by one. A sum of 999,999,999 (0x3B9AC9FF) is kept without a wrap. The stored nanosecond field is always below 10^9.
- R4: A write with select 0 loads wr_data (bits 63:32 whole ns, bits 31:0 fraction) as both the trim base and the active increment. The new increment is used from the next edge.
- R5: A write with select 1 sets the time on that edge: seconds = wr_data[63:32] zero-extended, nanoseconds = wr_data[31:0], fraction = 0. No increment is added on that edge.
- R6: A write with select 2 takes wr_data as a signed nanosecond delta with magnitude below 10^9. On the same edge the delta is added to the ticked time. A negative result borrows one second, and a result of 10^9 or more carries one second.
- R7: A write with select 3 takes wr_data[31:0] as a signed scaled-ppm trim. The active increment becomes base + (base × trim) / (10^6 × 2^16), with the quotient truncated toward zero. The base is the last value written with select 0.
- R8: A read strobe latches the seconds, nanoseconds and fraction held before that edge into rd_sec, rd_ns and rd_frac. rd_valid is high for exactly the following cycle. Without a read strobe the read outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; time advances on each rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Register select: 0 increment, 1 set, 2 adjust, 3 trim |
| wr_data | input | 64 | Write data |
| rd_en | input | 1 | Read strobe, latches a snapshot of the time |
| rd_valid | output | 1 | High for one cycle after a read strobe |
| rd_sec | output | SEC_W | Snapshot of seconds |
| rd_ns | output | 32 | Snapshot of nanoseconds |
| rd_frac | output | 32 | Snapshot of fraction of a nanosecond |

## Verification
The bench builds the block with SEC_W = 48 and CLK_HZ = 100 MHz. With these values the reset increment is a whole 10 ns, so the default rate can be checked exactly after a few cycles. The 48-bit seconds width lets a set at seconds 0xFFFFFFFF carry into bit 32, which shows that the counter is wider than the set field. The increments used include fractional steps, a step just below one second, and steps that land exactly on and just under the wrap value. Both trim signs are applied to the 10 ns base, and the expected times are computed with 128-bit arithmetic over the elapsed cycles.

// File: rtl/tod_pkg.sv
package tod_pkg;

  localparam logic [32:0] NS_PER_SEC = 33'd1_000_000_000;

  typedef enum logic [1:0] {
    SEL_INCR = 2'd0,
    SEL_SET  = 2'd1,
    SEL_ADJ  = 2'd2,
    SEL_TRIM = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [31:0] ns;
    logic [31:0] frac;
  } subsec_t;

  function automatic logic [63:0] nominal_incr(input logic [63:0] hz);
    return (64'd1_000_000_000 << 32) / hz;
  endfunction

  // base + base*trim / (1e6 * 2^16), quotient truncated toward zero
  function automatic logic [63:0] trimmed_incr(input logic [63:0] base,
                                               input logic signed [31:0] trim);
    logic signed [97:0] prod;
    prod = $signed({34'd0, base}) * $signed({{66{trim[31]}}, trim});
    return base + 64'(prod / 98'sd65_536_000_000);
  endfunction

  // one tick: add increment, wrap nanoseconds by subtracting one second
  function automatic subsec_t add_incr(input subsec_t cur, input logic [63:0] inc,
                                       output logic wrap);
    logic [32:0] f;
    logic [33:0] n;
    subsec_t res;
    f = {1'b0, cur.frac} + {1'b0, inc[31:0]};
    n = {2'b00, cur.ns} + {2'b00, inc[63:32]} + {33'd0, f[32]};
    wrap = (n >= {1'b0, NS_PER_SEC});
    if (wrap) n = n - {1'b0, NS_PER_SEC};
    res.ns   = n[31:0];
    res.frac = f[31:0];
    return res;
  endfunction

  // signed delta with |d| < 1e9, single borrow or carry
  function automatic logic [31:0] apply_delta(input logic [31:0] ns,
                                              input logic signed [34:0] d,
                                              output logic borrow,
                                              output logic carry);
    logic signed [34:0] s;
    s = $signed({3'b000, ns}) + d;
    borrow = (s < 35'sd0);
    carry  = (s >= 35'sd1_000_000_000);
    if (borrow) s = s + 35'sd1_000_000_000;
    else if (carry) s = s - 35'sd1_000_000_000;
    return s[31:0];
  endfunction

endpackage

// File: rtl/tod_incr_reg.sv
module tod_incr_reg #(
  parameter logic [63:0] DEF_INC = 64'h0000_000A_0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_en,
  input  logic [63:0] load_word,
  input  logic        trim_en,
  input  logic [31:0] trim_val,
  output logic [63:0] inc_q
);
  import tod_pkg::*;

  logic [63:0] base_q;
  logic [63:0] trim_inc;

  always_comb trim_inc = trimmed_incr(base_q, $signed(trim_val));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= DEF_INC;
      inc_q  <= DEF_INC;
    end else if (load_en) begin
      base_q <= load_word;
      inc_q  <= load_word;
    end else if (trim_en) begin
      inc_q  <= trim_inc;
    end
  end
endmodule

// File: rtl/tod_time_core.sv
module tod_time_core #(
  parameter int SEC_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       inc,
  input  logic              set_en,
  input  logic [63:0]       set_word,
  input  logic              adj_en,
  input  logic [34:0]       adj_delta,
  output logic [SEC_W-1:0]  sec_q,
  output logic [31:0]       ns_q,
  output logic [31:0]       frac_q,
  output logic              tick_wrap,
  output logic              adj_borrow,
  output logic              adj_carry
);
  import tod_pkg::*;

  subsec_t          cur, ticked;
  logic [31:0]      adj_ns;
  logic             b_raw, c_raw;
  logic [SEC_W-1:0] sec_tick, sec_adj;
  logic [SEC_W-1:0] sec_d;
  subsec_t          sub_d;

  always_comb begin
    cur.ns   = ns_q;
    cur.frac = frac_q;
    ticked   = add_incr(cur, inc, tick_wrap);
    sec_tick = sec_q + SEC_W'(tick_wrap);
    adj_ns   = apply_delta(ticked.ns, $signed(adj_delta), b_raw, c_raw);
    sec_adj  = sec_tick + SEC_W'(c_raw) - SEC_W'(b_raw);
    adj_borrow = adj_en & ~set_en & b_raw;
    adj_carry  = adj_en & ~set_en & c_raw;
    if (set_en) begin
      sec_d      = SEC_W'(set_word[63:32]);
      sub_d.ns   = set_word[31:0];
      sub_d.frac = 32'd0;
    end else if (adj_en) begin
      sec_d      = sec_adj;
      sub_d.ns   = adj_ns;
      sub_d.frac = ticked.frac;
    end else begin
      sec_d = sec_tick;
      sub_d = ticked;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      ns_q   <= '0;
      frac_q <= '0;
    end else begin
      sec_q  <= sec_d;
      ns_q   <= sub_d.ns;
      frac_q <= sub_d.frac;
    end
  end
endmodule

// File: rtl/tod_snapshot.sv
module tod_snapshot #(
  parameter int SEC_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [SEC_W-1:0]  sec,
  input  logic [31:0]       ns,
  input  logic [31:0]       frac,
  output logic              cap_valid,
  output logic [SEC_W-1:0]  cap_sec,
  output logic [31:0]       cap_ns,
  output logic [31:0]       cap_frac
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_valid <= 1'b0;
      cap_sec   <= '0;
      cap_ns    <= '0;
      cap_frac  <= '0;
    end else begin
      cap_valid <= cap_en;
      if (cap_en) begin
        cap_sec  <= sec;
        cap_ns   <= ns;
        cap_frac <= frac;
      end
    end
  end
endmodule

// File: rtl/tod_fracclk.sv
module tod_fracclk #(
  parameter int          SEC_W  = 48,
  parameter logic [63:0] CLK_HZ = 64'd100_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [63:0]       wr_data,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [SEC_W-1:0]  rd_sec,
  output logic [31:0]       rd_ns,
  output logic [31:0]       rd_frac
);
  import tod_pkg::*;

  localparam logic [63:0] DEF_INC = nominal_incr(CLK_HZ);

  logic             ev_load, ev_set, ev_adj, ev_trim;
  logic             ev_wrap, ev_borrow, ev_carry;
  logic [63:0]      incr;
  logic [SEC_W-1:0] time_sec;
  logic [31:0]      time_ns, time_frac;

  assign ev_load = wr_en && (reg_sel_e'(wr_addr) == SEL_INCR);
  assign ev_set  = wr_en && (reg_sel_e'(wr_addr) == SEL_SET);
  assign ev_adj  = wr_en && (reg_sel_e'(wr_addr) == SEL_ADJ);
  assign ev_trim = wr_en && (reg_sel_e'(wr_addr) == SEL_TRIM);

  tod_incr_reg #(.DEF_INC(DEF_INC)) u_incr (
    .clk(clk), .rst_n(rst_n),
    .load_en(ev_load), .load_word(wr_data),
    .trim_en(ev_trim), .trim_val(wr_data[31:0]),
    .inc_q(incr)
  );

  tod_time_core #(.SEC_W(SEC_W)) u_core (
    .clk(clk), .rst_n(rst_n), .inc(incr),
    .set_en(ev_set), .set_word(wr_data),
    .adj_en(ev_adj), .adj_delta(wr_data[34:0]),
    .sec_q(time_sec), .ns_q(time_ns), .frac_q(time_frac),
    .tick_wrap(ev_wrap), .adj_borrow(ev_borrow), .adj_carry(ev_carry)
  );

  tod_snapshot #(.SEC_W(SEC_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .cap_en(rd_en),
    .sec(time_sec), .ns(time_ns), .frac(time_frac),
    .cap_valid(rd_valid), .cap_sec(rd_sec), .cap_ns(rd_ns), .cap_frac(rd_frac)
  );
endmodule

module tod_fracclk_chk #(
  parameter int SEC_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic             rd_valid,
  input logic [31:0]      rd_ns,
  input logic [63:0]      wr_data,
  input logic             ev_load,
  input logic             ev_set,
  input logic             ev_adj,
  input logic             ev_wrap,
  input logic             ev_borrow,
  input logic             ev_carry,
  input logic [63:0]      incr,
  input logic [SEC_W-1:0] time_sec,
  input logic [31:0]      time_ns,
  input logic [31:0]      time_frac
);
  AST_NS_BELOW_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    time_ns < 32'd1_000_000_000); // R3

  AST_WRAP_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_set && !ev_adj && ev_wrap) |=> time_sec == $past(time_sec) + SEC_W'(1)); // R3

  AST_PLAIN_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_set && !ev_adj && !ev_wrap) |=> time_sec == $past(time_sec)); // R2

  AST_SET_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_set |=> (time_ns == $past(wr_data[31:0])) && (time_frac == 32'd0)); // R5

  AST_INC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> incr == $past(wr_data)); // R4

  AST_ADJ_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    ev_borrow |=> time_sec + SEC_W'(1) == $past(time_sec) + SEC_W'($past(ev_wrap))); // R6

  AST_ADJ_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_carry |=> time_sec == $past(time_sec) + SEC_W'($past(ev_wrap)) + SEC_W'(1)); // R6

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R8

  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid && $stable(rd_ns)); // R8
endmodule

bind tod_fracclk tod_fracclk_chk #(.SEC_W(SEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_valid(rd_valid), .rd_ns(rd_ns),
  .wr_data(wr_data), .ev_load(ev_load), .ev_set(ev_set), .ev_adj(ev_adj),
  .ev_wrap(ev_wrap), .ev_borrow(ev_borrow), .ev_carry(ev_carry), .incr(incr),
  .time_sec(time_sec), .time_ns(time_ns), .time_frac(time_frac)
);

// File: tb/test_tod_fracclk.sv
module test_tod_fracclk;
  localparam int SEC_W = 48;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [1:0]        wr_addr = 2'd0;
  logic [63:0]       wr_data = 64'd0;
  logic              rd_en = 1'b0;
  logic              rd_valid;
  logic [SEC_W-1:0]  rd_sec;
  logic [31:0]       rd_ns, rd_frac;

  int n_checks = 0;
  int n_errors = 0;

  always #5 clk = ~clk;

  tod_fracclk #(.SEC_W(SEC_W), .CLK_HZ(64'd100_000_000)) i_tod_fracclk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_sec(rd_sec), .rd_ns(rd_ns), .rd_frac(rd_frac)
  );

  localparam logic [63:0] BASE10 = 64'h0000_000A_0000_0000;

  localparam logic [63:0] V_INC [6] = '{
    64'h0000_000A_0000_0000, 64'h0000_0003_8000_0000, 64'h0000_0000_4000_0000,
    64'h0000_0001_0000_0000, {32'd999_999_999, 32'hFFFF_FFFF}, 64'h0000_0007_1234_5678};
  localparam logic [63:0] V_SET [6] = '{
    {32'd5, 32'd999_999_950}, {32'd0, 32'd0}, {32'd1, 32'h3B9A_C9FE},
    {32'd1, 32'd999_999_999}, {32'd7, 32'd999_999_999}, {32'hFFFF_FFFF, 32'd999_999_990}};
  localparam int unsigned V_N [6] = '{10, 7, 4, 1, 3, 2};

  function automatic void model(input logic [63:0] setw, input logic [63:0] inc,
                                input int unsigned n, output logic [SEC_W-1:0] es,
                                output logic [31:0] ens, output logic [31:0] ef);
    logic [127:0] unit, tot, rem;
    unit = 128'd1_000_000_000 << 32;
    tot  = ((128'(setw[63:32]) * 128'd1_000_000_000 + 128'(setw[31:0])) << 32)
           + 128'(inc) * 128'(n);
    es  = SEC_W'(tot / unit);
    rem = tot % unit;
    ens = rem[63:32];
    ef  = rem[31:0];
  endfunction

  task automatic check_time(input string req, input logic [SEC_W-1:0] es,
                            input logic [31:0] ens, input logic [31:0] ef);
    n_checks++;
    if (rd_sec !== es || rd_ns !== ens || rd_frac !== ef || rd_valid !== 1'b1) begin
      n_errors++;
      $display("FAIL %s: got sec=%0d ns=%0d frac=%h valid=%b expected sec=%0d ns=%0d frac=%h valid=1",
               req, rd_sec, rd_ns, rd_frac, rd_valid, es, ens, ef);
    end
  endtask

  task automatic check_bit(input string req, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic do_write(input logic [1:0] a, input logic [63:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read;
    rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic run_from(input logic [63:0] setw, input int unsigned n);
    do_write(2'd1, setw);
    repeat (n) @(posedge clk);
    @(negedge clk);
    do_read;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [SEC_W-1:0] es;
    logic [31:0]      ens, ef;
    logic [63:0]      tinc;

    // R1: reset state and default rate
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    check_time("R1 reset zero", '0, 32'd0, 32'd0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check_bit("R8 valid idle", rd_valid, 1'b0);
    do_read;
    check_time("R1 default 10ns step", '0, 32'd50, 32'd0);

    // R2 R3 R4 R5: vector table
    for (int i = 0; i < 6; i++) begin
      do_write(2'd0, V_INC[i]);
      run_from(V_SET[i], V_N[i]);
      model(V_SET[i], V_INC[i], V_N[i], es, ens, ef);
      check_time($sformatf("R2 R3 R4 R5 vector %0d", i), es, ens, ef);
    end

    // R3: 0x3B9AC9FF must be held (vector 2), check explicitly again
    do_write(2'd0, 64'h0000_0000_4000_0000);
    run_from({32'd1, 32'h3B9A_C9FE}, 4);
    check_time("R3 no early wrap", SEC_W'(1), 32'h3B9A_C9FF, 32'd0);

    // R6: adjust with borrow, carry, and tick-wrap then borrow
    do_write(2'd0, BASE10);
    do_write(2'd1, {32'd3, 32'd100});
    do_write(2'd2, 64'(-64'sd500));
    do_read;
    check_time("R6 borrow", SEC_W'(2), 32'd999_999_610, 32'd0);

    do_write(2'd1, {32'd3, 32'd999_999_900});
    do_write(2'd2, 64'd300);
    do_read;
    check_time("R6 carry", SEC_W'(4), 32'd210, 32'd0);

    do_write(2'd1, {32'd3, 32'd999_999_995});
    do_write(2'd2, 64'(-64'sd20));
    do_read;
    check_time("R6 wrap then borrow", SEC_W'(3), 32'd999_999_985, 32'd0);

    // R7: trim both signs on a 10 ns base
    do_write(2'd0, BASE10);
    do_write(2'd3, 64'd65536);
    tinc = 64'(longint'(BASE10) + (longint'(BASE10) * 64'sd65536) / 64'sd65_536_000_000);
    run_from(64'd0, 1000);
    model(64'd0, tinc, 1000, es, ens, ef);
    check_time("R7 positive trim", es, ens, ef);

    do_write(2'd3, 64'(-64'sd655360));
    tinc = 64'(longint'(BASE10) + (longint'(BASE10) * -64'sd655360) / 64'sd65_536_000_000);
    run_from(64'd0, 1000);
    model(64'd0, tinc, 1000, es, ens, ef);
    check_time("R7 negative trim", es, ens, ef);

    do_write(2'd0, BASE10);
    run_from(64'd0, 9);
    check_time("R4 reload clears trim", '0, 32'd90, 32'd0);

    // R8: outputs hold without a read strobe
    repeat (5) @(negedge clk);
    check_bit("R8 hold valid low", rd_valid, 1'b0);
    n_checks++;
    if (rd_ns !== 32'd90) begin
      n_errors++;
      $display("FAIL R8 hold: got ns=%0d expected 90", rd_ns);
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule